// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. The operand is cut into equal slices. Each slice derives a per-bit propagate term (the XOR of the operand bits) and a per-bit generate term (their AND). It forms every one of its internal carries as one flat sum of products, so no carry passes from bit to bit inside the slice. Each slice also reports one propagate/generate pair for the slice as a whole.

A second lookahead unit takes those slice pairs and the carry-in. It builds the carry into every upper slice and the final carry-out with the same sum-of-products form, one level up. No carry passes from slice to slice. The carry path therefore grows with the depth of the tree and not with the operand width. The default is four 4-bit slices, which gives a 16-bit adder.

Top module: `cla_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals op_a + op_b + carry_in as a (WIDTH+1)-bit unsigned value, where WIDTH = SLICE_W * SLICES.
- R2: The carry-in counts as a weight-1 addend. With both operands zero and carry_in = 1, sum is 1 and carry_out is 0. With carry_in = 0, sum is 0.
- R3: With op_a all ones, op_b zero and carry_in = 1, the carry runs the full width: sum is zero and carry_out is 1.
- R4: The carry that the second-level unit sends into each upper slice equals the carry out of the slice below, taken from that slice's own bits and its incoming carry.
- R5: When every slice propagates, carry_out equals carry_in.
- R6: No slice asserts its slice propagate and its slice generate at the same time.
- R7: A slice whose operand bits overflow on their own sends a carry into the next slice whatever the lower bits hold. For example, 0x0080 + 0x0080 gives 0x0100 with carry_out 0.
- R8: The outputs follow the inputs within the same evaluation, with no clock, no reset and no held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | SLICE_W*SLICES | First addend |
| op_b | input | SLICE_W*SLICES | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | SLICE_W*SLICES | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Whenever the inputs change, the immediate assertions check four things. The total matches the arithmetic sum. Each slice's own carry-out agrees with the carry that the second-level unit hands up. No slice propagates and generates at once. A fully propagating operand pair passes the carry-in straight through.

Only the bench's scenarios show the exact corner results: the full-width carry chain, a carry-in added to zero, an isolated slice overflow, and a reference comparison on new vectors every cycle.

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 4
) (
  input  logic [SLICE_W*SLICES-1:0] op_a,
  input  logic [SLICE_W*SLICES-1:0] op_b,
  input  logic                      carry_in,
  output logic [SLICE_W*SLICES-1:0] sum,
  output logic                      carry_out
);
  localparam int WIDTH = SLICE_W * SLICES;
  localparam int MW    = (SLICE_W > SLICES) ? SLICE_W : SLICES;

  logic [WIDTH-1:0]  prop, gen;
  logic [SLICES-1:0] sl_p, sl_g;
  logic [SLICES:0]   sl_c;

  assign prop = op_a ^ op_b;
  assign gen  = op_a & op_b;

  // carry after k positions, as one flat sum of products
  function automatic logic look(input logic [MW-1:0] pv, input logic [MW-1:0] gv,
                                input logic cin, input int k);
    logic acc, t;
    acc = cin;
    for (int m = 0; m < MW; m++) if (m < k) acc &= pv[m];
    for (int j = 0; j < MW; j++) begin
      if (j < k) begin
        t = gv[j];
        for (int m = 0; m < MW; m++) if (m > j && m < k) t &= pv[m];
        acc |= t;
      end
    end
    return acc;
  endfunction

  for (genvar q = 0; q < SLICES; q++) begin : g_slice
    logic [MW-1:0]      pe, ge;
    logic [SLICE_W-1:0] cc;
    always_comb begin
      pe = '0;
      ge = '0;
      pe[SLICE_W-1:0] = prop[q*SLICE_W +: SLICE_W];
      ge[SLICE_W-1:0] = gen[q*SLICE_W +: SLICE_W];
      for (int k = 0; k < SLICE_W; k++) cc[k] = look(pe, ge, sl_c[q], k);
      sl_p[q] = &prop[q*SLICE_W +: SLICE_W];
      sl_g[q] = look(pe, ge, 1'b0, SLICE_W);
    end
    assign sum[q*SLICE_W +: SLICE_W] = prop[q*SLICE_W +: SLICE_W] ^ cc;

    always_comb begin
      a_r6_pg_exclusive: assert (!(sl_p[q] && sl_g[q]))
        else $error("slice %0d propagates and generates", q);
      a_r4_slice_carry_agree: assert (look(pe, ge, sl_c[q], SLICE_W) == sl_c[q+1])
        else $error("slice %0d carry disagrees with second level", q);
    end
  end

  logic [MW-1:0] tp, tg;
  always_comb begin
    tp = '0;
    tg = '0;
    tp[SLICES-1:0] = sl_p;
    tg[SLICES-1:0] = sl_g;
    for (int k = 0; k <= SLICES; k++) sl_c[k] = look(tp, tg, carry_in, k);
  end
  assign carry_out = sl_c[SLICES];

  always_comb begin
    a_r1_total: assert ({carry_out, sum} == {1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in))
      else $error("total mismatch");
    a_r5_full_propagate: assert (!(&sl_p) || (carry_out == carry_in))
      else $error("propagate path broken");
  end
endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
  localparam int W = 16;
  logic clk = 1'b0;
  logic [W-1:0] a, b, s;
  logic ci, co;
  int checks = 0, failures = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  cla_adder dut (.op_a(a), .op_b(b), .carry_in(ci), .sum(s), .carry_out(co));

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc, input string req);
    longint exp;
    @(posedge clk);
    a = va; b = vb; ci = vc;
    @(negedge clk);
    exp = longint'(va) + longint'(vb) + longint'(vc);
    checks++;
    if ({co, s} !== exp[W:0]) begin
      failures++;
      $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h", req, va, vb, vc, {co, s}, exp[W:0]);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:16];
  endfunction

  initial begin
    a = '0; b = '0; ci = 1'b0;
    // R8: no reset, outputs settle straight from the inputs
    apply(16'h0000, 16'h0000, 1'b0, "R8 R2 zero");
    apply(16'h0000, 16'h0000, 1'b1, "R2 carry-in only");
    apply(16'hFFFF, 16'h0000, 1'b1, "R3 full chain");
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R1 all ones ci0");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R1 all ones ci1");
    apply(16'hAAAA, 16'h5555, 1'b0, "R5 propagate ci0");
    apply(16'hAAAA, 16'h5555, 1'b1, "R5 propagate ci1");
    apply(16'h0080, 16'h0080, 1'b0, "R7 slice overflow");
    apply(16'h0F00, 16'h0100, 1'b0, "R4 slice carry up");
    apply(16'h00FF, 16'h0001, 1'b0, "R4 two-slice carry");
    apply(16'h8000, 16'h8000, 1'b1, "R6 top generate");
    apply(16'h1234, 16'h4321, 1'b1, "R1 mixed");
    for (int i = 0; i < 2000; i++) apply(rnd(), rnd(), rnd() > 16'h7FFF, "R1 random");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule